// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Port

A full-duplex asynchronous serial port. The transmit path holds one word in a holding register while a second word shifts out. The receive path shifts a frame in while the previous word waits in a receive buffer. Both directions use start/stop framing. The data length can be set, and it depends on whether a parity bit is present. A multiprocessor option appends an address/data marker bit to every frame. A receiver that is asleep drops data frames and wakes only on address frames.

Bit timing comes from an oversampling tick. An internal 16-bit reload timer divides the system clock to produce it. A control bit can select the rising edges of an external clock input instead. The receiver takes 16 samples per bit and decides each bit by majority vote of the three middle samples. A start edge counts only if that vote is still low at mid-bit.

Software reaches four 16-bit registers through a simple write/read strobe interface. Index 0 is control, 1 is the timer reload, 2 is data and 3 is status. Parity, framing and overrun errors are recorded in status and stay set until software clears them.

Top module: `mp_uart`

## Requirements
- R1: After reset, status reads 0x0002 (only transmit-holding-empty set), control and reload read 0, and `txd_o` is high.
- R2: With the internal timer selected and reload N, the tick period is N+1 clock cycles, and each serial bit lasts 16 ticks, that is 16*(N+1) cycles.
- R3: Control bit 5 set makes each rising edge of `ext_clk_i` one tick, so a bit lasts 16 periods of that clock.
- R4: A frame is a low start bit, then data bits LSB first, then a high stop bit. Control bits [1:0] set the length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 give 9 bits. Each length is one less when parity is on.
- R5: Control bit 2 enables a parity bit right after the data bits. Control bit 3 selects odd parity (1) or even parity (0).
- R6: A write to index 2 loads the holding register from wdata[8:0]. The shifter takes the word as soon as it is idle. Status bit 1 reads 0 while the holding register waits on a busy shifter.
- R7: A received word is stored in the receive buffer and sets status bit 0. A read strobe at index 2 returns the word in rdata[8:0] and clears status bit 0.
- R8: A low pulse on the line shorter than 7 ticks produces no received word.
- R9: A parity mismatch sets status bit 2. The word is still stored.
- R10: A stop bit sampled low sets status bit 3. The word is still stored.
- R11: A word that completes while the receive buffer is full sets status bit 4 and is discarded, so the buffered word is kept.
- R12: Status bits 2 to 4 stay set until a write to index 3 with a 1 in the same bit position. A 0 in that position leaves the bit set.
- R13: Control bit 4 enables the marker bit, which follows parity (or data) and is taken from wdata[15]. The received marker reads as status bit 5. While control bit 6 (sleep) is set, frames with marker 0 are dropped and frames with marker 1 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops receive buffer at index 2) |
| addr_i | input | 2 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| ext_clk_i | input | 1 | External transfer clock |

## Verification
The transmitter is looped back into the receiver, and every frame shape is swept: three lengths, parity off, even or odd, and the marker bit on or off. The sweep uses all-zero, all-one and mixed data words, so a wrong bit count, bit order or parity polarity shows up as a wrong word or a spurious error. Handcrafted line waveforms then inject a short glitch, a wrong parity bit and a low stop bit. Each one triggers exactly one error flag or none, so sampling, voting and flag routing can be told apart. One-bit pulse widths under two reload values and under the external clock separate timer errors from shifter errors. Back-to-back writes, unread receptions and sleeping data frames exercise the buffering, overrun and address-filter paths.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  parameter int unsigned MAX_DATA = 9;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       mp_en;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(input frame_cfg_t c);
    logic [3:0] b;
    case (c.len_sel)
      2'd0:    b = 4'd7;
      2'd1:    b = 4'd8;
      default: b = 4'd9;
    endcase
    if (c.par_en) b = b - 4'd1;
    return b;
  endfunction
endpackage

// File: rtl/mp_uart_baud.sv
module mp_uart_baud #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TIMER_W-1:0] reload_i,
  input  logic               ext_sel_i,
  input  logic               ext_clk_i,
  output logic               tick_o
);
  logic [TIMER_W-1:0] cnt_q;
  logic [2:0]         ext_q;
  logic               int_tick, ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      ext_q <= {ext_q[1:0], ext_clk_i};
      if (ext_sel_i || cnt_q == '0) cnt_q <= reload_i;
      else                          cnt_q <= cnt_q - 1'b1;
    end
  end

  assign int_tick = !ext_sel_i && (cnt_q == '0);
  assign ext_tick = ext_q[1] && !ext_q[2];
  assign tick_o   = ext_sel_i ? ext_tick : int_tick;
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx import mp_uart_pkg::*; #(
  parameter int unsigned OSR   = 16,
  parameter int unsigned FRM_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  frame_cfg_t          cfg_i,
  input  logic                hold_full_i,
  input  logic [MAX_DATA-1:0] hold_data_i,
  input  logic                hold_addr_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                txd_o
);
  localparam int unsigned SW = $clog2(OSR);
  localparam int unsigned CW = $clog2(FRM_W + 1);

  logic [FRM_W-1:0] frm, sh_q;
  logic [CW-1:0]    len, left_q;
  logic [SW-1:0]    sub_q;
  logic             busy_q;

  // assemble start, data, parity, marker; unfilled bits stay 1 (stop)
  always_comb begin
    logic [3:0] nb, pos;
    logic       par;
    nb  = data_bits(cfg_i);
    frm = '1;
    frm[0] = 1'b0;
    par = cfg_i.par_odd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (4'(i) < nb) begin
        frm[i+1] = hold_data_i[i];
        par      = par ^ hold_data_i[i];
      end
    end
    pos = nb + 4'd1;
    if (cfg_i.par_en) begin
      frm[pos] = par;
      pos      = pos + 4'd1;
    end
    if (cfg_i.mp_en) begin
      frm[pos] = hold_addr_i;
      pos      = pos + 4'd1;
    end
    len = CW'(pos) + CW'(1);
  end

  assign take_o = hold_full_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      busy_q <= 1'b0;
    end else if (take_o) begin
      sh_q   <= frm;
      left_q <= len;
      sub_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      sub_q <= sub_q + SW'(1);
      if (sub_q == SW'(OSR - 1)) begin
        sh_q   <= {1'b1, sh_q[FRM_W-1:1]};
        left_q <= left_q - CW'(1);
        if (left_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = !busy_q || sh_q[0];
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx import mp_uart_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  frame_cfg_t          cfg_i,
  input  logic                rxd_i,
  output logic                done_o,
  output logic [MAX_DATA-1:0] data_o,
  output logic                mp_bit_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int unsigned SW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;

  logic [1:0]          sync_q;
  logic                run_q, par_q, mp_q, rxd_s, vote;
  logic [SW-1:0]       sub_q;
  logic [3:0]          idx_q, nb, par_pos, mp_pos, stop_pos;
  logic [1:0]          ones_q;
  logic [2:0]          ones3;
  logic [MAX_DATA-1:0] sh_q;
  logic                decide;

  assign rxd_s    = sync_q[1];
  assign nb       = data_bits(cfg_i);
  assign par_pos  = nb + 4'd1;
  assign mp_pos   = par_pos + {3'b0, cfg_i.par_en};
  assign stop_pos = mp_pos + {3'b0, cfg_i.mp_en};
  assign ones3    = {1'b0, ones_q} + {2'b0, rxd_s};
  assign vote     = ones3 >= 3'd2;
  assign decide   = run_q && tick_i && (sub_q == SW'(MID + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      run_q  <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      ones_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      mp_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) begin
        if (!run_q) begin
          if (!rxd_s) begin
            run_q  <= 1'b1;
            sub_q  <= SW'(1);
            idx_q  <= '0;
            ones_q <= '0;
            sh_q   <= '0;
          end
        end else begin
          sub_q <= sub_q + SW'(1);
          if (sub_q == SW'(OSR - 1)) idx_q <= idx_q + 4'd1;
          if (sub_q == SW'(MID - 1) || sub_q == SW'(MID))
            ones_q <= ones3[1:0];
          if (decide) begin
            ones_q <= '0;
            if (idx_q == 4'd0) begin
              if (vote) run_q <= 1'b0; // start not held: glitch
            end else if (idx_q <= nb) begin
              for (int i = 0; i < MAX_DATA; i++)
                if (idx_q == 4'(i + 1)) sh_q[i] <= vote;
            end else if (cfg_i.par_en && idx_q == par_pos) begin
              par_q <= vote;
            end else if (cfg_i.mp_en && idx_q == mp_pos) begin
              mp_q <= vote;
            end
            if (idx_q == stop_pos) run_q <= 1'b0;
          end
        end
      end
    end
  end

  assign done_o   = decide && (idx_q == stop_pos);
  assign data_o   = sh_q;
  assign mp_bit_o = mp_q;
  assign ferr_o   = !vote;
  assign perr_o   = cfg_i.par_en && ((^sh_q) ^ cfg_i.par_odd ^ par_q);
endmodule

// File: rtl/mp_uart.sv
module mp_uart import mp_uart_pkg::*; #(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned OSR     = 16,
  parameter int unsigned FRM_W   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  input  logic        ext_clk_i
);
  localparam int unsigned REG_W = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_BAUD = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;
  localparam int unsigned B_PE = 2, B_FE = 3, B_ORE = 4, B_EXT = 5, B_SLEEP = 6;

  logic [6:0]          ctrl_q;
  logic [TIMER_W-1:0]  reload_q;
  logic [MAX_DATA-1:0] hold_q, rxbuf_q, rx_data;
  logic                hold_full_q, hold_addr_q, rx_full_q, rx_addr_q;
  logic                pe_q, fe_q, ore_q;
  logic                tick, tx_take, tx_busy;
  logic                rx_done, rx_mp, rx_perr, rx_ferr;
  logic                wr_ctrl, wr_baud, wr_data, wr_stat, pop, accept, store;
  frame_cfg_t          cfg;

  assign cfg = '{len_sel: ctrl_q[1:0], par_en: ctrl_q[2], par_odd: ctrl_q[3], mp_en: ctrl_q[4]};

  mp_uart_baud #(.TIMER_W(TIMER_W)) baud_i (
    .clk_i, .rst_ni, .reload_i(reload_q), .ext_sel_i(ctrl_q[B_EXT]),
    .ext_clk_i, .tick_o(tick)
  );

  mp_uart_tx #(.OSR(OSR), .FRM_W(FRM_W)) tx_i (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg), .hold_full_i(hold_full_q),
    .hold_data_i(hold_q), .hold_addr_i(hold_addr_q), .take_o(tx_take),
    .busy_o(tx_busy), .txd_o
  );

  mp_uart_rx #(.OSR(OSR)) rx_i (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg), .rxd_i, .done_o(rx_done),
    .data_o(rx_data), .mp_bit_o(rx_mp), .perr_o(rx_perr), .ferr_o(rx_ferr)
  );

  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_baud = wr_en_i && addr_i == A_BAUD;
  assign wr_data = wr_en_i && addr_i == A_DATA;
  assign wr_stat = wr_en_i && addr_i == A_STAT;
  assign pop     = rd_en_i && addr_i == A_DATA;
  // sleeping receiver drops data frames
  assign accept  = rx_done && !(cfg.mp_en && ctrl_q[B_SLEEP] && !rx_mp);
  assign store   = accept && (!rx_full_q || pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      reload_q    <= '0;
      hold_q      <= '0;
      hold_addr_q <= 1'b0;
      hold_full_q <= 1'b0;
      rxbuf_q     <= '0;
      rx_addr_q   <= 1'b0;
      rx_full_q   <= 1'b0;
      pe_q        <= 1'b0;
      fe_q        <= 1'b0;
      ore_q       <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[6:0];
      if (wr_baud) reload_q <= TIMER_W'(wdata_i);
      if (wr_data) begin
        hold_q      <= wdata_i[MAX_DATA-1:0];
        hold_addr_q <= wdata_i[15];
        hold_full_q <= 1'b1;
      end else if (tx_take) begin
        hold_full_q <= 1'b0;
      end
      if (store) begin
        rxbuf_q   <= rx_data;
        rx_addr_q <= rx_mp;
        rx_full_q <= 1'b1;
      end else if (pop) begin
        rx_full_q <= 1'b0;
      end
      pe_q  <= (pe_q  && !(wr_stat && wdata_i[B_PE]))  || (store && rx_perr);
      fe_q  <= (fe_q  && !(wr_stat && wdata_i[B_FE]))  || (store && rx_ferr);
      ore_q <= (ore_q && !(wr_stat && wdata_i[B_ORE])) || (accept && rx_full_q && !pop);
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = REG_W'(ctrl_q);
      A_BAUD:  rdata_o = REG_W'(reload_q);
      A_DATA:  rdata_o = REG_W'(rxbuf_q);
      default: rdata_o = REG_W'({tx_busy, rx_addr_q, ore_q, fe_q, pe_q, !hold_full_q, rx_full_q});
    endcase
  end
endmodule

// File: rtl/mp_uart_chk.sv
module mp_uart_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [1:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic        txd_o,
  input logic        tick,
  input logic        ext_sel,
  input logic [15:0] reload,
  input logic        tx_busy,
  input logic        rx_done,
  input logic        rx_mp,
  input logic        mp_en,
  input logic        sleep,
  input logic        rx_full_q,
  input logic        ore_q
);
  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ext_sel && reload != '0) |=> (!tick || ext_sel));

  // R4
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !txd_o);

  // R7
  rx_fill_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(rx_done));

  // R11
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ore_q) |-> $past(rx_full_q));

  // R12
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ore_q && !(wr_en_i && addr_i == 2'd3 && wdata_i[4])) |=> ore_q);

  // R13
  sleep_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mp_en && sleep && rx_done && !rx_mp && !rx_full_q) |=> !rx_full_q);

  // R7
  pop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2 && !rx_done) |=> !rx_full_q);
endmodule

bind mp_uart mp_uart_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .txd_o(txd_o), .tick(tick),
  .ext_sel(ctrl_q[5]), .reload(16'(reload_q)), .tx_busy(tx_busy),
  .rx_done(rx_done), .rx_mp(rx_mp), .mp_en(ctrl_q[4]), .sleep(ctrl_q[6]),
  .rx_full_q(rx_full_q), .ore_q(ore_q)
);

// File: tb/mp_uart_tb_top.sv
module mp_uart_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        txd, rxd, drv = 1'b1, lb = 1'b1;
  logic        ext_clk = 1'b0, ext_run = 1'b0;
  int          nchk = 0, nfail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;
  assign rxd = lb ? txd : drv;

  mp_uart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd),
    .txd_o(txd), .ext_clk_i(ext_clk)
  );

  always begin
    if (ext_run) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end else @(negedge clk);
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(input logic [15:0] f, input int n);
    for (int i = 0; i < n; i++) begin drv = f[i]; idle(16); end
    drv = 1'b1; idle(40);
  endtask

  task automatic high_width(output int n);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    while (txd) begin n++; @(negedge clk); end
  endtask

  function automatic logic [15:0] ctrl_word(input int len, input int pe, input int odd, input int mp);
    return 16'(len | (pe << 2) | (odd << 3) | (mp << 4));
  endfunction

  initial begin
    logic [15:0] v, st;
    logic [8:0]  d, msk;
    int nb, len, pe, odd, nbits, w, ab;
    idle(4); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(2'd3, st); chk("R1 status", st, 16'h0002);
    rd(2'd0, v);  chk("R1 ctrl", v, 0);
    rd(2'd1, v);  chk("R1 reload", v, 0);
    chk("R1 txd idle", txd, 1);

    // R4 R5 R7 R13 loopback sweep over every frame shape
    for (int mp = 0; mp < 2; mp++) begin
      for (int ci = 0; ci < 9; ci++) begin
        len = ci % 3; pe = (ci >= 3) ? 1 : 0; odd = (ci >= 6) ? 1 : 0;
        nb = ((len == 0) ? 7 : (len == 1) ? 8 : 9) - pe;
        msk = 9'((1 << nb) - 1);
        nbits = 2 + nb + pe + mp;
        wr(2'd0, ctrl_word(len, pe, odd, mp));
        for (int k = 0; k < 8; k++) begin
          d  = (k == 0) ? 9'h000 : (k == 7) ? 9'h1FF : 9'((k * 157 + 53) & 511);
          ab = k & 1;
          wr(2'd2, {1'(ab), 6'b0, d});
          idle(nbits * 16 + 48);
          rd(2'd3, st);
          chk(pe ? "R5 status" : "R4 status", int'(st[4:0]), 5'b00011);
          if (mp == 1) chk("R13 marker", st[5], ab);
          pop(v);
          chk(pe ? "R5 data" : "R4 R7 data", int'(v[8:0]), int'(d & msk));
        end
      end
    end
    rd(2'd3, st); chk("R7 popped", st[0], 0);

    // R2 bit width with reload 3, then back to 0
    wr(2'd0, ctrl_word(1, 0, 0, 0));
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0001);
    high_width(w); chk("R2 bit width", w, 64);
    idle(10 * 64 + 100); pop(v); chk("R2 data", v[8:0], 9'h001);
    wr(2'd1, 16'd0);

    // R3 external clock, 6 cycles per edge
    ext_run = 1'b1;
    wr(2'd0, 16'h0020 | ctrl_word(1, 0, 0, 0));
    wr(2'd2, 16'h0001);
    high_width(w); chk("R3 bit width", w, 96);
    idle(10 * 96 + 150); pop(v); chk("R3 data", v[8:0], 9'h001);
    wr(2'd0, ctrl_word(1, 0, 0, 0));
    ext_run = 1'b0;

    // R6 double buffering
    wr(2'd2, 16'h0033);
    wr(2'd2, 16'h0044);
    rd(2'd3, st); chk("R6 holding busy", st[1], 0);
    idle(190); pop(v); chk("R6 first", v[8:0], 9'h033);
    idle(190); pop(v); chk("R6 second", v[8:0], 9'h044);
    rd(2'd3, st); chk("R6 holding empty", st[1], 1);

    // R8 glitch rejected, following frame still received
    lb = 1'b0;
    drv = 1'b0; idle(5); drv = 1'b1; idle(300);
    rd(2'd3, st); chk("R8 glitch", st[0], 0);
    send_raw(16'({1'b1, 8'h5A, 1'b0}), 10);
    pop(v); chk("R8 after glitch", v[8:0], 9'h05A);

    // R9 wrong parity, 8 bits even
    wr(2'd0, ctrl_word(2, 1, 0, 0));
    send_raw(16'({1'b1, 1'b1, 8'h03, 1'b0}), 11);
    rd(2'd3, st); chk("R9 parity flag", int'(st[4:2]), 3'b001);
    pop(v); chk("R9 data kept", v[8:0], 9'h003);
    // R12 clearing only the addressed bit
    wr(2'd3, 16'h0008);
    rd(2'd3, st); chk("R12 pe held", st[2], 1);
    wr(2'd3, 16'h0004);
    rd(2'd3, st); chk("R12 pe cleared", st[2], 0);

    // R10 low stop bit, 8N1
    wr(2'd0, ctrl_word(1, 0, 0, 0));
    send_raw(16'({1'b0, 8'hA5, 1'b0}), 10);
    idle(100);
    rd(2'd3, st); chk("R10 frame flag", int'(st[4:2]), 3'b010);
    pop(v); chk("R10 data kept", v[8:0], 9'h0A5);
    wr(2'd3, 16'h001C);
    rd(2'd3, st); chk("R12 all cleared", int'(st[4:0]), 5'b00010);

    // R11 overrun keeps first word
    lb = 1'b1;
    wr(2'd2, 16'h0011); idle(10 * 16 + 48);
    wr(2'd2, 16'h0022); idle(10 * 16 + 48);
    rd(2'd3, st); chk("R11 overrun flag", int'({st[4], st[0]}), 2'b11);
    pop(v); chk("R11 kept first", v[8:0], 9'h011);
    wr(2'd3, 16'h0010);
    rd(2'd3, st); chk("R12 ore cleared", st[4], 0);

    // R13 sleeping receiver
    wr(2'd0, 16'h0040 | ctrl_word(1, 0, 0, 1));
    wr(2'd2, 16'h0042); idle(11 * 16 + 48);
    rd(2'd3, st); chk("R13 data dropped", st[0], 0);
    wr(2'd2, 16'h8133); idle(11 * 16 + 48);
    rd(2'd3, st); chk("R13 address stored", int'({st[5], st[0]}), 2'b11);
    pop(v); chk("R13 address data", v[8:0], 9'h033);
    wr(2'd0, ctrl_word(1, 0, 0, 1));
    wr(2'd2, 16'h0077); idle(11 * 16 + 48);
    rd(2'd3, st); chk("R13 awake data", int'({st[5], st[0]}), 2'b01);
    pop(v); chk("R13 awake value", v[8:0], 9'h077);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule